// File: doc/BRIEF.md
# Iterative AES-128 Round Engine

The engine encrypts one 128-bit block at a time with a single round circuit that it reuses every clock. For each block that circuit is set to one of three modes. In the first cycle it only mixes the incoming block with the cipher key. In the middle cycles it runs a full round. In the last cycle it runs a round without column mixing. A separate key expander supplies the round keys. The engine asks that expander for the next key with a one-cycle advance pulse each time it consumes a key, so no round key is ever stored here.

Blocks enter and leave over valid/ready handshakes. The engine takes a block only while it is idle and no finished result is waiting, or in the same cycle that the waiting result is taken. A finished result stays on the output, unchanged, until the consumer raises `out_ready`. While a result waits, `in_ready` stays low, which back-pressures the producer. The key input is not handshaked: during every cycle in which `key_adv` is high, `rkey` must carry the key for the round being computed.

Top module: `aes_round_engine`

## Requirements
- R1: After reset, `out_valid` and `key_adv` are 0 and `in_ready` is 1.
- R2: A block is accepted on a clock edge where `in_valid` and `in_ready` are both 1. `in_ready` is 1 only when the engine is idle and either no result is pending or `out_ready` is 1. The cycle after an acceptance, `out_valid` is 0.
- R3: Bytes are ordered column-major. Bits 127:120 of `in_block` are row 0, column 0. Bits 119:112 are row 1, column 0, and so on, one column per 32 bits. `out_block` uses the same ordering.
- R4: `key_adv` is high in the acceptance cycle and in each of the following NR cycles, which is NR+1 consecutive cycles in all. The key for round i must be on `rkey` in the i-th of these cycles, counting from 0. `key_adv` is low at all other times.
- R5: `out_valid` becomes 1 on the (NR+1)-th rising edge, counting the acceptance edge as the first.
- R6: Round 0 is a plain XOR of the input block with `rkey`. Rounds 1 to NR-1 apply SubBytes, ShiftRow, MixColumn and then the key XOR. Round NR applies the same steps but leaves out MixColumn.
- R7: ShiftRow rotates row r left by r byte positions (r = 0..3). Row 1 column 0 takes the byte from row 1 column 1.
- R8: MixColumn multiplies each column by {03}x^3+{01}x^2+{01}x+{02} modulo x^4+1. The {02} product is a 1-bit left shift, XORed with 8'h1B when bit 7 was set. The {03} product is the {02} product XOR the byte itself.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_block` holds its value, `in_ready` is 0, `key_adv` is 0, and `in_valid` has no effect.
- R10: Plaintext 00112233445566778899aabbccddeeff under key 000102030405060708090a0b0c0d0e0f gives 69c4e0d86a7b0430d8cdb78070b4c55a.
- R11: When `out_ready` is 1 in the cycle a result is pending, a new block can be accepted in that same cycle, and both handshakes complete on one edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Plaintext block offered |
| in_ready | output | 1 | Engine can take a block this cycle |
| in_block | input | 128 | Plaintext, column-major bytes |
| rkey | input | 128 | Current round key from the expander |
| key_adv | output | 1 | Current key consumed; expander moves to the next one |
| out_valid | output | 1 | Ciphertext available |
| out_ready | input | 1 | Consumer takes the ciphertext |
| out_block | output | 128 | Ciphertext, column-major bytes |

## Verification
The hardest case to reach is a single edge on which a pending result is taken and a new block is accepted. On that edge the output handshake, the input handshake and the restart of the key sequence all coincide. The stimulus leaves each result pending for a random number of stalled cycles and offers junk input during the stall. The next block is then presented in the same cycle that `out_ready` rises. The expander model in the bench wraps its key index after NR+1 advances. Any extra or missing `key_adv` pulse therefore shifts the keys for every later block and corrupts every ciphertext that follows.

// File: rtl/aes_eng_pkg.sv
package aes_eng_pkg;

  localparam int unsigned BLK_W   = 128;
  localparam int unsigned N_BYTES = BLK_W / 8;

  typedef enum logic [1:0] {
    RM_INIT  = 2'd0,
    RM_STD   = 2'd1,
    RM_FINAL = 2'd2
  } rmode_e;

  function automatic logic [7:0] gf_x2(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p;
    logic [7:0] t;
    p = 8'h00;
    t = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ t;
      t = gf_x2(t);
    end
    return p;
  endfunction

  // multiplicative inverse as a^254 (0 maps to 0), then the affine map
  function automatic logic [7:0] sbox_fn(input logic [7:0] a);
    logic [7:0] sq;
    logic [7:0] acc;
    logic [7:0] b;
    sq  = a;
    acc = 8'h01;
    for (int k = 1; k < 8; k++) begin
      sq  = gf_mul(sq, sq);
      acc = gf_mul(acc, sq);
    end
    b = acc;
    return b ^ {b[6:0], b[7]} ^ {b[5:0], b[7:6]} ^ {b[4:0], b[7:5]}
             ^ {b[3:0], b[7:4]} ^ 8'h63;
  endfunction

endpackage

// File: rtl/aes_sbox.sv
module aes_sbox (
  input  logic [7:0] a,
  output logic [7:0] y
);
  import aes_eng_pkg::*;

  always_comb y = sbox_fn(a);

endmodule

// File: rtl/aes_mixcol.sv
module aes_mixcol (
  input  logic [31:0] col_i,
  output logic [31:0] col_o
);
  import aes_eng_pkg::*;

  logic [7:0] a0, a1, a2, a3;

  always_comb begin
    a0 = col_i[31:24];
    a1 = col_i[23:16];
    a2 = col_i[15:8];
    a3 = col_i[7:0];
    col_o[31:24] = gf_x2(a0) ^ gf_x2(a1) ^ a1 ^ a2 ^ a3;
    col_o[23:16] = a0 ^ gf_x2(a1) ^ gf_x2(a2) ^ a2 ^ a3;
    col_o[15:8]  = a0 ^ a1 ^ gf_x2(a2) ^ gf_x2(a3) ^ a3;
    col_o[7:0]   = gf_x2(a0) ^ a0 ^ a1 ^ a2 ^ gf_x2(a3);
  end

endmodule

// File: rtl/aes_round_unit.sv
module aes_round_unit
  import aes_eng_pkg::*;
(
  input  logic [BLK_W-1:0] din,
  input  logic [BLK_W-1:0] rkey,
  input  rmode_e           mode,
  output logic [BLK_W-1:0] dout
);

  localparam int unsigned NCOL = N_BYTES / 4;

  logic [BLK_W-1:0] sub_w;
  logic [BLK_W-1:0] shf_w;
  logic [BLK_W-1:0] mix_w;

  genvar gi, gc, gr;
  generate
    for (gi = 0; gi < N_BYTES; gi++) begin : g_sub
      aes_sbox u_sb (
        .a (din[BLK_W-1-8*gi -: 8]),
        .y (sub_w[BLK_W-1-8*gi -: 8])
      );
    end
    for (gc = 0; gc < NCOL; gc++) begin : g_col
      for (gr = 0; gr < 4; gr++) begin : g_row
        // byte (row gr, col gc) is taken from column (gc+gr) mod 4
        assign shf_w[BLK_W-1-8*(4*gc+gr) -: 8] =
          sub_w[BLK_W-1-8*(4*((gc+gr)%NCOL)+gr) -: 8];
      end
      aes_mixcol u_mc (
        .col_i (shf_w[BLK_W-1-32*gc -: 32]),
        .col_o (mix_w[BLK_W-1-32*gc -: 32])
      );
    end
  endgenerate

  always_comb begin
    unique case (mode)
      RM_INIT:  dout = din ^ rkey;
      RM_FINAL: dout = shf_w ^ rkey;
      default:  dout = mix_w ^ rkey;
    endcase
  end

endmodule

// File: rtl/aes_round_ctrl.sv
module aes_round_ctrl
  import aes_eng_pkg::*;
#(
  parameter int unsigned NR = 10
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   in_valid,
  input  logic   out_ready,
  output logic   in_ready,
  output logic   accept,
  output logic   load,
  output logic   key_adv,
  output rmode_e mode,
  output logic   out_valid
);

  localparam int unsigned RW = $clog2(NR + 1);

  logic          busy_q;
  logic [RW-1:0] rnd_q;
  logic          last_w;

  always_comb begin
    in_ready = !busy_q && (!out_valid || out_ready);
    accept   = in_valid && in_ready;
    last_w   = busy_q && (rnd_q == RW'(NR));
    load     = accept || busy_q;
    key_adv  = load;
    if (accept)      mode = RM_INIT;
    else if (last_w) mode = RM_FINAL;
    else             mode = RM_STD;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      rnd_q     <= '0;
      out_valid <= 1'b0;
    end else begin
      if (accept) begin
        busy_q <= 1'b1;
        rnd_q  <= RW'(1);
      end else if (last_w) begin
        busy_q <= 1'b0;
      end else if (busy_q) begin
        rnd_q  <= rnd_q + RW'(1);
      end
      if (last_w)         out_valid <= 1'b1;
      else if (out_ready) out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/aes_round_engine.sv
module aes_round_engine
  import aes_eng_pkg::*;
#(
  parameter int unsigned NR = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [127:0] in_block,
  input  logic [127:0] rkey,
  output logic         key_adv,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [127:0] out_block
);

  logic             accept;
  logic             load;
  rmode_e           mode;
  logic [BLK_W-1:0] state_q;
  logic [BLK_W-1:0] rin_w;
  logic [BLK_W-1:0] rout_w;

  aes_round_ctrl #(.NR(NR)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .in_ready  (in_ready),
    .accept    (accept),
    .load      (load),
    .key_adv   (key_adv),
    .mode      (mode),
    .out_valid (out_valid)
  );

  // input select: fresh block on acceptance, fed-back state otherwise
  assign rin_w = accept ? in_block : state_q;

  aes_round_unit u_round (
    .din  (rin_w),
    .rkey (rkey),
    .mode (mode),
    .dout (rout_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)    state_q <= '0;
    else if (load) state_q <= rout_w;
  end

  assign out_block = state_q;

endmodule

// File: rtl/aes_round_engine_chk.sv
module aes_round_engine_chk #(
  parameter int unsigned NR = 10
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         key_adv,
  input logic         out_valid,
  input logic         out_ready,
  input logic [127:0] out_block
);

  localparam int unsigned CW = $clog2(NR + 3);
  logic [CW-1:0] adv_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                     adv_cnt <= '0;
    else if (in_valid && in_ready)  adv_cnt <= CW'(1);
    else if (key_adv)               adv_cnt <= adv_cnt + CW'(1);
  end

  assert_rst_state_R1: assert property (@(posedge clk)
    !rst_n |=> !out_valid && !key_adv);

  assert_accept_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !out_valid);

  assert_idle_no_adv_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |-> !key_adv);

  assert_adv_ends_at_result_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(key_adv) |-> $rose(out_valid));

  assert_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> adv_cnt == CW'(NR + 1));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_block));

  assert_backpressure_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready && !key_adv);

endmodule

bind aes_round_engine aes_round_engine_chk #(.NR(NR)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .key_adv   (key_adv),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_block (out_block)
);

// File: tb/tb_aes_round_engine.sv
`timescale 1ns/1ps
module tb_aes_round_engine;

  localparam int NR = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [127:0] in_block = '0;
  logic [127:0] rkey;
  logic         key_adv;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [127:0] out_block;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  aes_round_engine #(.NR(NR)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_block(in_block), .rkey(rkey), .key_adv(key_adv),
    .out_valid(out_valid), .out_ready(out_ready), .out_block(out_block)
  );

  // ---------------- reference model ----------------
  logic [7:0]   bsb [256];
  logic [127:0] rks [NR+1];

  function automatic logic [7:0] bxt(input logic [7:0] a);
    return (a << 1) ^ ((a & 8'h80) != 0 ? 8'h1b : 8'h00);
  endfunction

  task automatic build_sbox();
    logic [7:0] p, q, x;
    p = 8'h01; q = 8'h01;
    do begin
      p = p ^ (p << 1) ^ (p[7] ? 8'h1b : 8'h00);
      q = q ^ (q << 1); q = q ^ (q << 2); q = q ^ (q << 4);
      if (q[7]) q = q ^ 8'h09;
      x = q ^ {q[6:0], q[7]} ^ {q[5:0], q[7:6]} ^ {q[4:0], q[7:5]} ^ {q[3:0], q[7:4]};
      bsb[p] = x ^ 8'h63;
    end while (p != 8'h01);
    bsb[0] = 8'h63;
  endtask

  task automatic expand_key(input logic [127:0] key);
    logic [31:0] w [44];
    logic [31:0] t;
    logic [7:0]  rc;
    rc = 8'h01;
    for (int i = 0; i < 4; i++) w[i] = key[127-32*i -: 32];
    for (int i = 4; i < 44; i++) begin
      t = w[i-1];
      if (i % 4 == 0) begin
        t = {t[23:0], t[31:24]};
        t = {bsb[t[31:24]], bsb[t[23:16]], bsb[t[15:8]], bsb[t[7:0]]};
        t[31:24] = t[31:24] ^ rc;
        rc = bxt(rc);
      end
      w[i] = w[i-4] ^ t;
    end
    for (int r = 0; r <= NR; r++) rks[r] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
  endtask

  function automatic logic [127:0] ref_encrypt(input logic [127:0] pt);
    logic [7:0] s [16];
    logic [7:0] n [16];
    logic [127:0] res;
    for (int i = 0; i < 16; i++) s[i] = pt[127-8*i -: 8] ^ rks[0][127-8*i -: 8];
    for (int r = 1; r <= NR; r++) begin
      for (int c = 0; c < 4; c++)
        for (int w = 0; w < 4; w++) n[4*c+w] = bsb[s[4*((c+w)%4)+w]];
      if (r != NR) begin
        for (int c = 0; c < 4; c++) begin
          s[4*c]   = bxt(n[4*c]) ^ bxt(n[4*c+1]) ^ n[4*c+1] ^ n[4*c+2] ^ n[4*c+3];
          s[4*c+1] = n[4*c] ^ bxt(n[4*c+1]) ^ bxt(n[4*c+2]) ^ n[4*c+2] ^ n[4*c+3];
          s[4*c+2] = n[4*c] ^ n[4*c+1] ^ bxt(n[4*c+2]) ^ bxt(n[4*c+3]) ^ n[4*c+3];
          s[4*c+3] = bxt(n[4*c]) ^ n[4*c] ^ n[4*c+1] ^ n[4*c+2] ^ bxt(n[4*c+3]);
        end
      end else begin
        for (int i = 0; i < 16; i++) s[i] = n[i];
      end
      for (int i = 0; i < 16; i++) s[i] = s[i] ^ rks[r][127-8*i -: 8];
    end
    for (int i = 0; i < 16; i++) res[127-8*i -: 8] = s[i];
    return res;
  endfunction

  // ---------------- key expander model ----------------
  int kidx;
  int adv_seen;
  always @(posedge clk) begin
    if (!rst_n) begin
      kidx <= 0;
      adv_seen <= 0;
    end else if (key_adv) begin
      kidx <= (kidx == NR) ? 0 : kidx + 1;
      adv_seen <= adv_seen + 1;
    end
  end
  assign rkey = rks[kidx];

  // ---------------- checking helpers ----------------
  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  // Present one block; any pending result is taken in the same cycle.
  // Leaves the new result pending for `stall` cycles with junk on the input.
  task automatic run_block(input logic [127:0] pt, input logic [127:0] key,
                           input int stall, input string tag);
    logic [127:0] exp;
    logic [127:0] held;
    bit pend;
    int lat;
    int adv0;
    expand_key(key);
    exp = ref_encrypt(pt);
    @(negedge clk);
    pend = out_valid;
    out_ready = 1'b1;
    in_valid = 1'b1;
    in_block = pt;
    #1;
    chk(in_ready == 1'b1, pend ? "R11 accept while result taken" : "R2 ready when idle",
        {127'd0, in_ready}, 128'd1);
    adv0 = adv_seen;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    out_ready = 1'b0;
    in_block = rnd128();
    chk(out_valid == 1'b0, "R2 valid low after accept", {127'd0, out_valid}, 128'd0);
    lat = 1;
    while (!out_valid && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    chk(lat == NR + 1, "R5 latency", 128'(lat), 128'(NR + 1));
    chk(adv_seen - adv0 == NR + 1, "R4 key advance count", 128'(adv_seen - adv0), 128'(NR + 1));
    chk(out_block == exp, {"R6 R7 R8 R3 ciphertext ", tag}, out_block, exp);
    held = out_block;
    for (int k = 0; k < stall; k++) begin
      in_valid = 1'b1;
      in_block = rnd128();
      #1;
      chk(in_ready == 1'b0 && key_adv == 1'b0, "R9 back-pressure",
          {126'd0, in_ready, key_adv}, 128'd0);
      @(negedge clk);
      chk(out_valid && out_block == held, "R9 result held", out_block, held);
    end
    in_valid = 1'b0;
  endtask

  // ---------------- main sequence ----------------
  initial begin
    logic [127:0] c0;
    void'($urandom(32'd4242));
    build_sbox();
    expand_key('0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0 && key_adv == 1'b0 && in_ready == 1'b1, "R1 reset state",
        {125'd0, out_valid, key_adv, in_ready}, 128'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1 && key_adv == 1'b0, "R1 idle after reset",
        {126'd0, in_ready, key_adv}, 128'd2);

    // R10 known vector
    run_block(128'h00112233445566778899aabbccddeeff,
              128'h000102030405060708090a0b0c0d0e0f, 0, "known");
    c0 = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;
    chk(out_block == c0, "R10 known answer", out_block, c0);

    // directed corners, back-to-back (R11) and with stalls (R9)
    run_block('0, '0, 3, "zeros");
    run_block('1, '1, 0, "ones");
    run_block(128'h80000000000000000000000000000001, 128'h01, 5, "edge bits");

    for (int n = 0; n < 40; n++)
      run_block(rnd128(), rnd128(), int'($urandom_range(0, 4)), "random");

    @(negedge clk);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk(out_valid == 1'b0 && in_ready == 1'b1, "R2 result consumed",
        {126'd0, out_valid, in_ready}, 128'd1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R5 actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule